// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an eight-bit general-purpose I/O port. Each bit has a direction bit. An output bit drives the value held in the data register. An input bit drives high on its output pin, and its data-register bit follows the level on the matching input pin. Software reaches the port through a simple register bus with four signals: address, write enable, write data, and read data. Read data is combinational and has no wait states.

All accesses below byte offset 0x400 land on the data register. For these accesses, word-address bits [9:2] form a per-bit mask. A read returns only the masked bits and the other bits read as zero. A write changes only the bits that are masked and also set as outputs. This lets software set or clear single pins without a read-modify-write sequence.

The direction register is at offset 0x400. A read-only window of twelve identification bytes sits at the top of the 4 KB space. Every other offset reads zero and ignores writes. The port is one register stage deep: a write or a pin change becomes visible on the clock edge that captures it.

Top module: `gpio_maskport`

## Requirements
- R1: A read at any offset below 0x400 returns the data register ANDed with mask = offset bits [9:2], zero-extended to 32 bits.
- R2: A write at an offset below 0x400 updates data bit i from write-data bit i only when mask bit i (offset bit i+2) is 1 and direction bit i is 1. All other data bits are left as they are.
- R3: A write to offset 0x400 stores write-data bits [7:0] as the direction register. A read of 0x400 returns it zero-extended.
- R4: Output pin i equals data bit i when direction bit i is 1 (output), and equals 1 when direction bit i is 0 (input).
- R5: On every clock edge, each data bit whose direction is input takes the level of its input pin. Pin changes on output bits have no effect on the data register.
- R6: A read at offset 0xFD0 + 4k (k = 0..11) returns identification byte k in bits [7:0] and zero above. The bytes, for k = 0..11, are 00 00 00 00 58 1F 00 00 A2 71 3E 9C (hex).
- R7: Reads at any other offset (for example 0x404, 0x41C, 0x800, 0xFCC) return zero. Writes there change neither register.
- R8: After reset the data and direction registers are zero. All bits are inputs and all output pins read 1.
- R9: A register write changes the output pins on the clock edge that performs the write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 8 | External input pin levels |
| pin_out | output | 8 | Output pin drive |

## Verification
On every cycle, the bound assertions check the following:
- the masked and direction-gated data write, including that unmasked bits are preserved;
- the direction store;
- the input-pin capture limited to input bits;
- the high drive of input bits;
- the zero read on unmapped offsets.

The bench scenarios are needed for the rest. They cover the masked read values under several masks and the identification byte contents. They show that a pin change on an output bit leaves the data untouched. They cover the reset state and the exact edge at which a write reaches the pins.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
    localparam int GPIO_W   = 8;
    localparam int ADDR_W   = 12;
    localparam int BUS_W    = 32;
    localparam int ID_COUNT = 12;
    localparam logic [ID_COUNT*8-1:0] ID_VALUE = 96'h9C3E71A2_00001F58_00000000;

    typedef struct packed {
        logic [GPIO_W-1:0] data;
        logic [GPIO_W-1:0] dir;
    } gpio_state_t;
endpackage

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
    import gpio_mp_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int W        = GPIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              win_hit,
    input  logic              dir_hit,
    input  logic [W-1:0]      mask,
    input  logic [W-1:0]      wval,
    input  logic [W-1:0]      pins,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      drive
);
    gpio_state_t st_d, st_q;
    logic [W-1:0] wmask;

    always_comb begin
        st_d  = st_q;
        wmask = mask & st_q.dir;
        // input bits follow pins, output bits hold
        st_d.data = (st_q.data & st_q.dir) | (pins & ~st_q.dir);
        if (wr_en && win_hit)
            st_d.data = (st_d.data & ~wmask) | (wval & wmask);
        if (wr_en && dir_hit)
            st_d.dir = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign dir_q  = st_q.dir;
    assign drive  = (st_q.data & st_q.dir) | ~st_q.dir;
endmodule

// File: rtl/gpio_mp_idrom.sv
module gpio_mp_idrom
    import gpio_mp_pkg::*;
#(
    parameter int COUNT = ID_COUNT,
    parameter logic [COUNT*8-1:0] VALUE = ID_VALUE
) (
    input  logic [$clog2(COUNT)-1:0] idx,
    output logic [7:0]               id_byte
);
    logic [7:0] table_w [COUNT];

    for (genvar k = 0; k < COUNT; k++) begin : g_byte
        assign table_w[k] = VALUE[k*8 +: 8];
    end

    always_comb begin
        id_byte = '0;
        for (int k = 0; k < COUNT; k++)
            if (idx == k[$clog2(COUNT)-1:0]) id_byte = table_w[k];
    end
endmodule

// File: rtl/gpio_mp_rdmux.sv
module gpio_mp_rdmux
    import gpio_mp_pkg::*;
#(
    parameter int W  = GPIO_W,
    parameter int BW = BUS_W
) (
    input  logic          win_hit,
    input  logic          dir_hit,
    input  logic          id_hit,
    input  logic [W-1:0]  mask,
    input  logic [W-1:0]  data_q,
    input  logic [W-1:0]  dir_q,
    input  logic [7:0]    id_byte,
    output logic [BW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (win_hit)     rdata[W-1:0] = data_q & mask;
        else if (dir_hit) rdata[W-1:0] = dir_q;
        else if (id_hit)  rdata[7:0]   = id_byte;
    end
endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport
    import gpio_mp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int W  = GPIO_W,
    parameter int BW = BUS_W,
    parameter int NID = ID_COUNT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out
);
    localparam int WORD_W   = AW - 2;
    localparam int IDX_W    = $clog2(NID);
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << W);
    localparam logic [WORD_W-1:0] ID_WORD  = WORD_W'((1 << WORD_W) - NID);

    logic [WORD_W-1:0] word;
    logic [W-1:0]      mask, data_q, dir_q;
    logic              win_hit, dir_hit, id_hit;
    logic [WORD_W-1:0] id_off;
    logic [7:0]        id_byte;
    logic              unused_bits;

    assign word    = bus_addr[AW-1:2];
    assign mask    = bus_addr[W+1:2];
    assign win_hit = (word >> W) == '0;
    assign dir_hit = word == DIR_WORD;
    assign id_hit  = word >= ID_WORD;
    assign id_off  = word - ID_WORD;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BW-1:W], id_off[WORD_W-1:IDX_W]};

    gpio_mp_regs #(.ADDR_W_P(AW), .W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .win_hit(win_hit),
        .dir_hit(dir_hit),
        .mask   (mask),
        .wval   (bus_wdata[W-1:0]),
        .pins   (pin_in),
        .data_q (data_q),
        .dir_q  (dir_q),
        .drive  (pin_out)
    );

    gpio_mp_idrom #(.COUNT(NID), .VALUE(ID_VALUE)) u_id (
        .idx    (id_off[IDX_W-1:0]),
        .id_byte(id_byte)
    );

    gpio_mp_rdmux #(.W(W), .BW(BW)) u_rd (
        .win_hit(win_hit),
        .dir_hit(dir_hit),
        .id_hit (id_hit),
        .mask   (mask),
        .data_q (data_q),
        .dir_q  (dir_q),
        .id_byte(id_byte),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk #(
    parameter int AW = 12,
    parameter int W  = 8,
    parameter int BW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [BW-1:0] bus_wdata,
    input logic [BW-1:0] bus_rdata,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  data_q,
    input logic [W-1:0]  dir_q
);
    logic data_acc, dir_acc, unmapped;
    logic [W-1:0] amask;
    assign data_acc = bus_addr < AW'(1 << (W + 2));
    assign dir_acc  = bus_addr[AW-1:2] == (AW-2)'(1 << W);
    assign unmapped = !data_acc && !dir_acc && (bus_addr < AW'(12'hFD0));
    assign amask    = bus_addr[W+1:2];

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && data_acc) |=> (((data_q ^ $past(bus_wdata[W-1:0])) & $past(amask & dir_q)) == '0)); // R2
    AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && data_acc) |=> (((data_q ^ $past(data_q)) & $past(~amask & dir_q)) == '0)); // R2
    AST_DIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dir_acc) |=> (dir_q == $past(bus_wdata[W-1:0]))); // R3
    AST_INPUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~dir_q) == ~dir_q)); // R4
    AST_PIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((data_q ^ $past(pin_in)) & $past(~dir_q)) == '0)); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0)); // R7
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> (dir_q == $past(dir_q))); // R7
endmodule

bind gpio_maskport gpio_maskport_chk #(.AW(AW), .W(W), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .data_q   (data_q),
    .dir_q    (dir_q)
);

// File: tb/tb_gpio_maskport.sv
module tb_gpio_maskport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_maskport dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R8 pins", {24'h0, pin_out}, 32'hFF);
        bus_read(12'h400, v); check("R8 dir", v, 0);
        bus_read(12'h3FC, v); check("R8 data", v, 0);
    endtask

    task automatic t_dir;
        logic [31:0] v;
        bus_write(12'h400, 32'h1234_5A0F);
        bus_read(12'h400, v); check("R3 dir", v, 32'h0F);
        check("R4 out", {24'h0, pin_out}, 32'hF0);
    endtask

    task automatic t_masked_write;
        logic [31:0] v;
        bus_write(12'h014, 32'hFF);           // mask 0x05, both outputs
        bus_read(12'h3FC, v); check("R2 masked", v, 32'h05);
        check("R4 out", {24'h0, pin_out}, 32'hF5);
        bus_write(12'h3C0, 32'hFF);           // mask 0xF0, all inputs
        bus_read(12'h3FC, v); check("R2 dir gate", v, 32'h05);
    endtask

    task automatic t_masked_read;
        logic [31:0] v;
        pin_in = 8'hA0;
        repeat (2) @(negedge clk);
        bus_read(12'h0F0, v); check("R1 mask3C", v, 32'h24);
        bus_read(12'h3FC, v); check("R5 capture", v, 32'hA5);
        bus_read(12'h000, v); check("R1 mask0", v, 32'h00);
        bus_read(12'h204, v); check("R1 mask81", v, 32'h81);
        check("R4 in-high", {24'h0, pin_out}, 32'hF5);
    endtask

    task automatic t_ignore_out_pins;
        logic [31:0] v;
        pin_in = 8'h5F;
        repeat (2) @(negedge clk);
        bus_read(12'h3FC, v); check("R5 ignore", v, 32'h55);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h58, 8'h1F,
                                    8'h00, 8'h00, 8'hA2, 8'h71, 8'h3E, 8'h9C};
        logic [31:0] v;
        for (int k = 0; k < 12; k++) begin
            bus_read(12'hFD0 + 12'(4 * k), v);
            check("R6 id", v, {24'h0, exp_id[k]});
        end
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_read(12'h404, v); check("R7 rd404", v, 0);
        bus_read(12'h41C, v); check("R7 rd41C", v, 0);
        bus_read(12'h800, v); check("R7 rd800", v, 0);
        bus_read(12'hFCC, v); check("R7 rdFCC", v, 0);
        bus_write(12'h404, 32'hFF);
        bus_write(12'h800, 32'hFF);
        bus_read(12'h400, v); check("R7 dir kept", v, 32'h0F);
        bus_read(12'h3FC, v); check("R7 data kept", v, 32'h55);
        check("R7 pins kept", {24'h0, pin_out}, 32'hF5);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr = 12'h03C; bus_wdata = 32'h0A; bus_wr = 1'b1;
        #5 check("R9 before", {24'h0, pin_out}, 32'hF5);
        @(posedge clk);
        #1 check("R9 after", {24'h0, pin_out}, 32'hFA);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_write(12'h400, 32'h00);
        check("R4 all in", {24'h0, pin_out}, 32'hFF);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_masked_write();
        t_masked_read();
        t_ignore_out_pins();
        t_id();
        t_unmapped();
        t_timing();
        finish_run();
    end
endmodule